// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash bus. After software has launched a program or erase operation on the flash part, it pulses `start`, and the poller works out when the operation has finished and whether it worked. It does this by issuing status reads through a simple request/valid read handshake. It compares one toggle bit across two reads in a row. The toggle bit is bit 6 or bit 2 of the status byte, chosen by `bit_sel`. Bit 5 of the status byte is the device's exceeded-time-limit flag.

When the toggle bit stays the same across a pair, the operation has finished and the result is a pass. When it keeps changing and bit 5 is low, the poller reads another pair. When it keeps changing and bit 5 is high, one more confirmation pair is read, because toggling can stop at the same moment the flag rises. If that pair still toggles, the poller writes the reset command byte 0xF0 itself and then reports a fail. A host-side limit on toggling pairs also ends a stuck operation with a reset write and a fail.

The states are ST_IDLE, ST_RD_FIRST, ST_RD_SECOND, ST_RST_WR and ST_DONE. The transitions are:
- ST_IDLE to ST_RD_FIRST on `start`.
- ST_RD_FIRST to ST_RD_SECOND when a read is accepted.
- ST_RD_SECOND to ST_DONE on an equal pair.
- ST_RD_SECOND to ST_RD_FIRST for another pair: after a toggling pair with bit 5 low and the limit not yet reached, or after the first toggling pair with bit 5 high.
- ST_RD_SECOND to ST_RST_WR after a toggling confirmation pair, or at the limit.
- ST_RST_WR to ST_DONE when the write is accepted.
- ST_DONE to ST_IDLE always.
- ST_RD_FIRST or ST_RD_SECOND to ST_IDLE on `abort`.

Top module: `flash_toggle_poll`

## Requirements
- R1: After reset the block is idle, with `rd_req`, `wr_req`, `done` and `pass` all low.
- R2: A `start` seen while idle begins a fresh check of two accepted reads. The toggle bit is status bit 6 when `bit_sel`=0 and bit 2 when `bit_sel`=1. Only the selected toggle bit and bit 5 affect the outcome.
- R3: A pair whose toggle bits are equal ends the run with `done` and `pass`=1, without a write.
- R4: A toggling pair whose second read has bit 5 low causes another pair of reads, while the count of such pairs stays below MAX_PAIRS.
- R5: A toggling pair whose second read has bit 5 high causes exactly one confirmation pair. If that pair is equal, the result is `pass`=1.
- R6: A confirmation pair that still toggles causes one write of data 0xF0, and then `done` with `pass`=0.
- R7: The MAX_PAIRS-th toggling pair with bit 5 low causes one write of 0xF0, and then `done` with `pass`=0.
- R8: `done` is a single-cycle pulse, and `pass` is valid during it.
- R9: `rd_req` stays high until a cycle with `rd_valid`, and `wr_req` stays high until a cycle with `wr_ack`. A transfer happens on a cycle where both are high. `rd_req` and `wr_req` are never high together.
- R10: `abort` during reading returns the block to idle with no `done` and no write. The next `start` needs two new reads before it can report.
- R11: `abort` during the reset write is ignored: the write completes and a fail is reported.
- R12: `start` while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (used only when idle) |
| abort | input | 1 | Give up polling during reads |
| bit_sel | input | 1 | 0: toggle bit is bit 6; 1: toggle bit is bit 2 |
| rd_req | output | 1 | Status read request |
| rd_data | input | 8 | Returned status byte |
| rd_valid | input | 1 | Read data valid; completes the read |
| wr_req | output | 1 | Reset command write request |
| wr_data | output | 8 | Write data (0xF0 during the write) |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result with `done`: 1 success, 0 failure |

## Verification
A wrong stored toggle value or a wrong confirmation flag shows up as a different number of accepted reads before `done`. It can also show as a flipped `pass`, or as an extra or missing 0xF0 write. All of these are visible on the cycle `done` rises, a few pairs after the fault. A pair counter that is off by one shifts the timeout by exactly two reads. A sweep over where toggling stops and where bit 5 rises, for both bit selections, pins these effects to individual pairs.

// File: rtl/flash_toggle_poll_pkg.sv
package flash_toggle_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_RST_WR,
        ST_DONE
    } poll_state_t;

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned FLAG_BIT = 5;
    localparam int unsigned TOGGLE_HI = 6;
    localparam int unsigned TOGGLE_LO = 2;
    localparam logic [STATUS_W-1:0] RESET_CMD = 8'hF0;
endpackage

// File: rtl/poll_toggle_cmp.sv
module poll_toggle_cmp
    import flash_toggle_poll_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                bit_sel,
    input  logic [STATUS_W-1:0] status,
    output logic                changed,
    output logic                flag
);
    logic held_q;
    logic cur_bit;

    always_comb begin
        cur_bit = bit_sel ? status[TOGGLE_LO] : status[TOGGLE_HI];
        changed = cur_bit != held_q;
        flag    = status[FLAG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (capture) begin
            held_q <= cur_bit;
        end
    end
endmodule

// File: rtl/poll_pair_ctr.sv
module poll_pair_ctr #(
    parameter int unsigned MAX_PAIRS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int unsigned CW = $clog2(MAX_PAIRS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] cnt_q;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the counter never passes its limit
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_PAIRS));
endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll
    import flash_toggle_poll_pkg::*;
#(
    parameter int unsigned MAX_PAIRS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       bit_sel,
    output logic       rd_req,
    input  logic [7:0] rd_data,
    input  logic       rd_valid,
    output logic       wr_req,
    output logic [7:0] wr_data,
    input  logic       wr_ack,
    output logic       done,
    output logic       pass
);
    poll_state_t state_q, state_d;
    logic pass_q, pass_d;
    logic confirm_q, confirm_d;
    logic cap, ctr_clr, ctr_inc;
    logic changed, flag, at_last;

    poll_toggle_cmp cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .bit_sel (bit_sel),
        .status  (rd_data),
        .changed (changed),
        .flag    (flag)
    );

    poll_pair_ctr #(.MAX_PAIRS(MAX_PAIRS)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .at_last (at_last)
    );

    always_comb begin
        state_d   = state_q;
        pass_d    = pass_q;
        confirm_d = confirm_q;
        cap       = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_RD_FIRST;
                    confirm_d = 1'b0;
                    ctr_clr   = 1'b1;
                end
            end
            ST_RD_FIRST: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (rd_valid) begin
                    cap     = 1'b1;
                    state_d = ST_RD_SECOND;
                end
            end
            ST_RD_SECOND: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (rd_valid) begin
                    if (!changed) begin
                        pass_d  = 1'b1;
                        state_d = ST_DONE;
                    end else if (confirm_q) begin
                        pass_d  = 1'b0;
                        state_d = ST_RST_WR;
                    end else if (flag) begin
                        confirm_d = 1'b1;
                        state_d   = ST_RD_FIRST;
                    end else if (at_last) begin
                        pass_d  = 1'b0;
                        state_d = ST_RST_WR;
                    end else begin
                        ctr_inc = 1'b1;
                        state_d = ST_RD_FIRST;
                    end
                end
            end
            ST_RST_WR: begin
                if (wr_ack) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pass_q    <= 1'b0;
            confirm_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            pass_q    <= pass_d;
            confirm_q <= confirm_d;
        end
    end

    always_comb begin
        rd_req  = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
        wr_req  = (state_q == ST_RST_WR);
        wr_data = wr_req ? RESET_CMD : 8'h00;
        done    = (state_q == ST_DONE);
        pass    = pass_q;
    end

    // R9: read and write never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R9: a pending write is held until accepted
    a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req);
    // R9: a pending read is held until accepted or aborted
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid && !abort |=> rd_req);
    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a failure is reported only after the reset write
    a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done && !pass |-> $past(wr_req && wr_ack));
    // R3: a success never follows a write
    a_r3_pass_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done && pass |-> !$past(wr_req));
    // R11: abort does not cancel the reset write
    a_r11_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack && abort |=> wr_req);
endmodule

// File: tb/flash_toggle_poll_tb_top.sv
module flash_toggle_poll_tb_top;
    localparam int MAXP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0, bit_sel = 1'b0;
    logic rd_req, rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic wr_req, wr_ack = 1'b0;
    logic [7:0] wr_data;
    logic done, pass;

    int checks = 0, fails = 0;
    int cyc = 0;
    int rd_count = 0, wr_count = 0;
    logic [7:0] last_wr = 8'h00;
    int t_s = 0, f_s = 99;
    bit rstall = 1'b0, wstall = 1'b0, whold = 1'b0;

    always #10 clk = ~clk;

    flash_toggle_poll #(.MAX_PAIRS(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .bit_sel(bit_sel),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
        .done(done), .pass(pass)
    );

    function automatic bit tbit(int n, int t);
        return (n < t) ? n[0] : t[0];
    endfunction

    function automatic logic [7:0] status_of(int n, int t, int f, bit sel);
        logic [7:0] d;
        d = {n[4], 1'b0, 1'b0, n[3:2], 1'b0, n[1:0]};
        d[5] = (n >= f);
        d[6] = sel ? n[0] : tbit(n, t);
        d[2] = sel ? tbit(n, t) : n[0];
        return d;
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rd_req && rd_valid) rd_count = rd_count + 1;
        if (wr_req && wr_ack) begin
            wr_count = wr_count + 1;
            last_wr = wr_data;
        end
    end

    always @(negedge clk) begin
        rd_valid = rd_req && !(rstall && cyc[0]);
        rd_data  = status_of(rd_count, t_s, f_s, bit_sel);
        wr_ack   = wr_req && !whold && !(wstall && cyc[0]);
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_run(int t, int f, output bit ok, output int reads, output int writes);
        bit conf;
        int cnt;
        int n;
        conf = 0; cnt = 0; n = 0; ok = 0; writes = 1;
        forever begin
            bit a, b, d5;
            a = tbit(n, t); b = tbit(n + 1, t); d5 = (n + 1 >= f);
            n = n + 2;
            if (a == b) begin ok = 1; writes = 0; break; end
            if (conf) break;
            if (d5) conf = 1;
            else begin
                cnt = cnt + 1;
                if (cnt >= MAXP) break;
            end
        end
        reads = n;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run(int t, int f, bit sel, bit stall, bit poke);
        bit e_ok, seen;
        int e_rd, e_wr;
        t_s = t; f_s = f; bit_sel = sel; rstall = stall; wstall = stall;
        rd_count = 0; wr_count = 0; last_wr = 8'h00;
        ref_run(t, f, e_ok, e_rd, e_wr);
        pulse_start();
        if (poke) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_done(seen);
        check(seen, "R8", seen, 1);
        check(pass == e_ok, e_ok ? "R3/R5 pass" : "R6/R7 fail", pass, e_ok);
        check(rd_count == e_rd, poke ? "R12 reads" : "R2/R4 reads", rd_count, e_rd);
        check(wr_count == e_wr, "R6/R7 writes", wr_count, e_wr);
        if (e_wr == 1) check(last_wr == 8'hF0, "R6 data", last_wr, 240);
        @(negedge clk);
        check(!done, "R8 pulse", done, 0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        check(!rd_req && !wr_req && !done && !pass, "R1", {rd_req, wr_req, done, pass}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !wr_req && !done && !pass, "R1", {rd_req, wr_req, done, pass}, 0);

        // sweep: where toggling stops, where bit 5 rises, which bit toggles
        for (int s = 0; s < 2; s++)
            for (int t = 0; t <= 12; t++)
                for (int f = 0; f <= 13; f++)
                    run(t, (f == 13) ? 99 : f, s[0], (t + f) % 2 == 1, 1'b0);

        // R12: start while busy
        run(5, 99, 1'b0, 1'b0, 1'b1);
        run(9, 3, 1'b1, 1'b1, 1'b1);

        // R10: abort during reading, then restart needs two fresh reads
        t_s = 40; f_s = 99; bit_sel = 1'b0; rstall = 0; wstall = 0;
        rd_count = 0; wr_count = 0;
        pulse_start();
        for (int i = 0; i < 50 && rd_count < 3; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!rd_req && !done && !wr_req, "R10 idle", {rd_req, done, wr_req}, 0);
        end
        check(wr_count == 0, "R10 no write", wr_count, 0);
        t_s = 0; rd_count = 0;
        pulse_start();
        wait_done(seen);
        check(seen && pass, "R10 restart pass", pass, 1);
        check(rd_count == 2, "R10 fresh reads", rd_count, 2);

        // R11: abort during the reset write
        t_s = 40; f_s = 0; rd_count = 0; wr_count = 0; whold = 1'b1;
        pulse_start();
        for (int i = 0; i < 50 && !wr_req; i++) @(negedge clk);
        check(wr_req && wr_data == 8'hF0, "R11 write", wr_data, 240);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        @(negedge clk);
        check(wr_req, "R11 held", wr_req, 1);
        whold = 1'b0;
        wait_done(seen);
        check(seen && !pass, "R11 fail", pass, 0);
        check(wr_count == 1, "R11 one write", wr_count, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule